// File: doc/BRIEF.md
# Read Strobe Delay Sweep Eye Finder

This block trains the receive strobe delay of every byte lane of a memory data path. After a start pulse it walks a signed delay offset across a fixed range, one value per step. For each value it raises a step request toward an external tester, which runs one read pattern check and returns a pass/fail feedback code per lane together with a completion strobe. The block then clears the receiver training indication and pulses a datapath reset before it moves to the next offset.

Each lane keeps its own record of the longest unbroken run of passing offsets. When the sweep ends, the block reports the run's first and last offset, its width and its center for each lane. It also gives a final unsigned delay code, rebased at the sweep start, and a flag when the eye is too narrow to trust. The per-lane rising and falling strobe codes sit at the midpoint while a sweep runs. They take the trained value only when the sweep is complete, so the strobe setting seen during training never changes.

Top module: `rsd_sweep_top`

## Requirements
- R1: After reset, `done_o`, `step_req_o`, `train_mode_o` and `dp_rst_o` are low, and every lane's `code_p_o` and `code_n_o` hold the midpoint code 32.
- R2: A sweep presents the offsets -32, -31, ... up to +31 on `delay_o`, one per step and in increasing order: 64 steps in all, with +32 never presented.
- R3: The block leaves a step only when `step_done_i` is high while `step_req_o` is high. While it waits, `delay_o` stays unchanged. A `step_done_i` at any other time is ignored, and a `start_i` during a sweep is ignored.
- R4: A lane passes at a step only when its 2-bit feedback field equals exactly 1. The values 0, 2 and 3 count as fails and end any run in progress.
- R5: Each lane reports its longest contiguous run of passing offsets. When two runs have equal length, the one at the lower offset is kept.
- R6: `width_o` = end - start + 1. `center_o` = floor((start + end) / 2), rounding toward minus infinity.
- R7: `fail_o` of a lane is set when its width is at most 12. A lane with no passing step reports width 0, start, end and center equal to -32, and is flagged. The sweep still completes for every lane.
- R8: At the end of a sweep, `code_p_o` and `code_n_o` of a lane both become center + 32. A start pulse returns both to 32, and they stay there for the whole sweep.
- R9: In the cycle after an accepted step, `step_req_o` and `train_mode_o` are low and `dp_rst_o` is high for exactly one cycle. Only after that is the next offset requested.
- R10: `done_o` is a single-cycle pulse. It rises together with the final results, two cycles after the last step is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse that begins a sweep when idle |
| step_done_i | input | 1 | Tester completion strobe for the current step |
| fb_i | input | LANES x FB_W | Per-lane feedback code, valid with step_done_i |
| delay_o | output | DLY_W | Signed offset under test |
| step_req_o | output | 1 | Request to the tester to run a check at delay_o |
| train_mode_o | output | 1 | Receiver training indication, high while a check is pending |
| dp_rst_o | output | 1 | One-cycle datapath reset after each step |
| busy_o | output | 1 | Sweep in progress |
| res_start_o | output | LANES x DLY_W | Signed first offset of the best run |
| res_end_o | output | LANES x DLY_W | Signed last offset of the best run |
| width_o | output | LANES x LEN_W | Width of the best run |
| center_o | output | LANES x DLY_W | Signed center of the best run |
| code_p_o | output | LANES x CODE_W | Rising-edge strobe delay code |
| code_n_o | output | LANES x CODE_W | Falling-edge strobe delay code |
| fail_o | output | LANES | Narrow or missing eye flag |
| done_o | output | 1 | One-cycle pulse when results are valid |

## Verification
The bench builds the block with its defaults: four lanes, 2-bit feedback, a 64-step sweep from -32 and a minimum width of 12. These values let a single run hold lanes with two competing windows, equal-length ties, a window that reaches the final +31 step, a pass at every offset, an exactly-12-wide eye and a lane that never passes. Its tester model waits a varying number of cycles before completing each step. It also sends stray completion strobes and start pulses, which exercises the handshake at every offset.

// File: rtl/rsd_sweep_pkg.sv
package rsd_sweep_pkg;

    typedef enum logic [1:0] {
        SW_IDLE = 2'd0,
        SW_REQ  = 2'd1,
        SW_RST  = 2'd2,
        SW_FIN  = 2'd3
    } sweep_state_e;

    // Feedback code that marks a passing lane
    localparam int PASS_CODE = 1;

    function automatic int code_bits(input int steps);
        return (steps > 1) ? $clog2(steps) : 1;
    endfunction

endpackage

// File: rtl/rsd_sweep_seq.sv
module rsd_sweep_seq
    import rsd_sweep_pkg::*;
#(
    parameter int DLY_W       = 7,
    parameter int SWEEP_START = -32,
    parameter int SWEEP_STEPS = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    step_done_i,
    output logic signed [DLY_W-1:0] delay_o,
    output logic                    step_req_o,
    output logic                    train_mode_o,
    output logic                    dp_rst_o,
    output logic                    rec_o,
    output logic                    clr_o,
    output logic                    fin_o,
    output logic                    busy_o
);
    localparam logic signed [DLY_W-1:0] FIRST_D = DLY_W'(SWEEP_START);
    localparam logic signed [DLY_W-1:0] LAST_D  = DLY_W'(SWEEP_START + SWEEP_STEPS - 1);

    sweep_state_e            state_q;
    logic signed [DLY_W-1:0] delay_q;

    assign step_req_o   = (state_q == SW_REQ);
    assign train_mode_o = (state_q == SW_REQ);
    assign dp_rst_o     = (state_q == SW_RST);
    assign fin_o        = (state_q == SW_FIN);
    assign busy_o       = (state_q != SW_IDLE);
    assign rec_o        = step_req_o && step_done_i;
    assign clr_o        = (state_q == SW_IDLE) && start_i;
    assign delay_o      = delay_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SW_IDLE;
            delay_q <= FIRST_D;
        end else begin
            unique case (state_q)
                SW_IDLE: if (start_i) begin
                    state_q <= SW_REQ;
                    delay_q <= FIRST_D;
                end
                SW_REQ: if (step_done_i) state_q <= SW_RST;
                SW_RST: begin
                    if (delay_q == LAST_D) begin
                        state_q <= SW_FIN;
                    end else begin
                        state_q <= SW_REQ;
                        delay_q <= delay_q + DLY_W'(1);
                    end
                end
                SW_FIN: state_q <= SW_IDLE;
                default: state_q <= SW_IDLE;
            endcase
        end
    end

    // R3: a pending request holds its offset until completed
    a_r3_hold_offset: assert property (@(posedge clk) disable iff (rst)
        (step_req_o && !step_done_i) |=> (step_req_o && $stable(delay_o)));

    // R9: each accepted step is followed by the datapath reset cycle
    a_r9_reset_after_step: assert property (@(posedge clk) disable iff (rst)
        rec_o |=> (dp_rst_o && !train_mode_o));

    // R9: reset lasts one cycle
    a_r9_reset_single: assert property (@(posedge clk) disable iff (rst)
        dp_rst_o |=> !dp_rst_o);

    // R2: requested offsets stay within the sweep range
    a_r2_offset_range: assert property (@(posedge clk) disable iff (rst)
        step_req_o |-> (delay_o >= FIRST_D && delay_o <= LAST_D));

endmodule

// File: rtl/rsd_lane_tracker.sv
module rsd_lane_tracker
    import rsd_sweep_pkg::*;
#(
    parameter int DLY_W       = 7,
    parameter int LEN_W       = 7,
    parameter int FB_W        = 2,
    parameter int SWEEP_START = -32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr_i,
    input  logic                    rec_i,
    input  logic [FB_W-1:0]         fb_i,
    input  logic signed [DLY_W-1:0] delay_i,
    output logic signed [DLY_W-1:0] best_start_o,
    output logic [LEN_W-1:0]        best_len_o
);
    localparam logic signed [DLY_W-1:0] FIRST_D = DLY_W'(SWEEP_START);

    logic                    pass;
    logic [LEN_W-1:0]        cur_len_q, next_len;
    logic signed [DLY_W-1:0] cur_start_q, run_start;

    assign pass      = (fb_i == FB_W'(PASS_CODE));
    assign next_len  = cur_len_q + LEN_W'(1);
    assign run_start = (cur_len_q == '0) ? delay_i : cur_start_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cur_len_q    <= '0;
            cur_start_q  <= FIRST_D;
            best_len_o   <= '0;
            best_start_o <= FIRST_D;
        end else if (rec_i) begin
            if (pass) begin
                cur_len_q   <= next_len;
                cur_start_q <= run_start;
                // strictly longer only: an equal later run loses
                if (next_len > best_len_o) begin
                    best_len_o   <= next_len;
                    best_start_o <= run_start;
                end
            end else begin
                cur_len_q <= '0;
            end
        end
    end

    // R5: the recorded best run never shrinks within a sweep
    a_r5_best_monotonic: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (best_len_o >= $past(best_len_o)));

    // R4: a failing step leaves the best record untouched
    a_r4_fail_no_gain: assert property (@(posedge clk) disable iff (rst)
        (rec_i && !pass && !clr_i) |=> ($stable(best_len_o) && $stable(best_start_o)));

endmodule

// File: rtl/rsd_lane_eval.sv
module rsd_lane_eval #(
    parameter int DLY_W       = 7,
    parameter int LEN_W       = 7,
    parameter int CODE_W      = 6,
    parameter int SWEEP_START = -32,
    parameter int MIN_WIDTH   = 12
) (
    input  logic signed [DLY_W-1:0] best_start_i,
    input  logic [LEN_W-1:0]        best_len_i,
    output logic signed [DLY_W-1:0] end_o,
    output logic signed [DLY_W-1:0] center_o,
    output logic [CODE_W-1:0]       code_o,
    output logic                    fail_o
);
    localparam int EW = DLY_W + 2;
    localparam logic signed [EW-1:0] START_X = EW'(SWEEP_START);

    logic                 empty;
    logic signed [EW-1:0] s_x, len_x, e_x, sum_x, mid_x, ctr_x, code_x;

    assign empty  = (best_len_i == '0);
    assign s_x    = EW'(best_start_i);
    assign len_x  = EW'(best_len_i);
    assign e_x    = s_x + len_x - EW'(1);
    assign sum_x  = s_x + e_x;
    assign mid_x  = sum_x >>> 1;
    assign ctr_x  = empty ? s_x : mid_x;
    assign code_x = ctr_x - START_X;

    assign end_o    = empty ? best_start_i : e_x[DLY_W-1:0];
    assign center_o = ctr_x[DLY_W-1:0];
    assign code_o   = code_x[CODE_W-1:0];
    assign fail_o   = (best_len_i <= LEN_W'(MIN_WIDTH));

    // R6: the center lies inside the reported run
    always_comb begin
        a_r6_center_inside: assert (empty || (mid_x >= s_x && mid_x <= e_x));
    end

endmodule

// File: rtl/rsd_sweep_top.sv
module rsd_sweep_top
    import rsd_sweep_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int FB_W        = 2,
    parameter int DLY_W       = 7,
    parameter int SWEEP_START = -32,
    parameter int SWEEP_STEPS = 64,
    parameter int MIN_WIDTH   = 12,
    parameter int LEN_W       = $clog2(SWEEP_STEPS + 1),
    parameter int CODE_W      = code_bits(SWEEP_STEPS)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start_i,
    input  logic                              step_done_i,
    input  logic [LANES-1:0][FB_W-1:0]        fb_i,
    output logic [DLY_W-1:0]                  delay_o,
    output logic                              step_req_o,
    output logic                              train_mode_o,
    output logic                              dp_rst_o,
    output logic                              busy_o,
    output logic [LANES-1:0][DLY_W-1:0]       res_start_o,
    output logic [LANES-1:0][DLY_W-1:0]       res_end_o,
    output logic [LANES-1:0][LEN_W-1:0]       width_o,
    output logic [LANES-1:0][DLY_W-1:0]       center_o,
    output logic [LANES-1:0][CODE_W-1:0]      code_p_o,
    output logic [LANES-1:0][CODE_W-1:0]      code_n_o,
    output logic [LANES-1:0]                  fail_o,
    output logic                              done_o
);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(SWEEP_STEPS / 2);
    localparam logic [DLY_W-1:0]  FIRST_D  = DLY_W'(SWEEP_START);

    logic                    rec, clr, fin;
    logic signed [DLY_W-1:0] delay_s;

    rsd_sweep_seq #(
        .DLY_W(DLY_W), .SWEEP_START(SWEEP_START), .SWEEP_STEPS(SWEEP_STEPS)
    ) seq_i (
        .clk(clk), .rst(rst), .start_i(start_i), .step_done_i(step_done_i),
        .delay_o(delay_s), .step_req_o(step_req_o), .train_mode_o(train_mode_o),
        .dp_rst_o(dp_rst_o), .rec_o(rec), .clr_o(clr), .fin_o(fin), .busy_o(busy_o)
    );
    assign delay_o = delay_s;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [DLY_W-1:0] b_start, l_end, l_ctr;
        logic [LEN_W-1:0]        b_len;
        logic [CODE_W-1:0]       l_code;
        logic                    l_fail;

        rsd_lane_tracker #(
            .DLY_W(DLY_W), .LEN_W(LEN_W), .FB_W(FB_W), .SWEEP_START(SWEEP_START)
        ) trk_i (
            .clk(clk), .rst(rst), .clr_i(clr), .rec_i(rec), .fb_i(fb_i[g]),
            .delay_i(delay_s), .best_start_o(b_start), .best_len_o(b_len)
        );

        rsd_lane_eval #(
            .DLY_W(DLY_W), .LEN_W(LEN_W), .CODE_W(CODE_W),
            .SWEEP_START(SWEEP_START), .MIN_WIDTH(MIN_WIDTH)
        ) eval_i (
            .best_start_i(b_start), .best_len_i(b_len), .end_o(l_end),
            .center_o(l_ctr), .code_o(l_code), .fail_o(l_fail)
        );

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                res_start_o[g] <= FIRST_D;
                res_end_o[g]   <= FIRST_D;
                center_o[g]    <= FIRST_D;
                width_o[g]     <= '0;
                fail_o[g]      <= 1'b0;
                code_p_o[g]    <= MID_CODE;
                code_n_o[g]    <= MID_CODE;
            end else if (fin) begin
                res_start_o[g] <= b_start;
                res_end_o[g]   <= l_end;
                center_o[g]    <= l_ctr;
                width_o[g]     <= b_len;
                fail_o[g]      <= l_fail;
                code_p_o[g]    <= l_code;
                code_n_o[g]    <= l_code;
            end
        end

        // R8: both strobe codes sit at the midpoint while sweeping
        a_r8_codes_held: assert property (@(posedge clk) disable iff (rst)
            busy_o |-> (code_p_o[g] == MID_CODE && code_n_o[g] == MID_CODE));

        // R8: rising and falling codes always agree
        a_r8_codes_equal: assert property (@(posedge clk) disable iff (rst)
            code_p_o[g] == code_n_o[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) done_o <= 1'b0;
        else     done_o <= fin;
    end

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10: completion only when the sweep has wound down
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !step_req_o));

endmodule

// File: tb/rsd_sweep_top_tb.sv
module rsd_sweep_top_tb_top;
    localparam int LANES = 4;
    localparam int FB_W  = 2;
    localparam int DLY_W = 7;
    localparam int LEN_W = 7;
    localparam int CW    = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic step_done_i = 1'b0;
    logic [LANES-1:0][FB_W-1:0] fb_i = '0;
    logic [DLY_W-1:0] delay_o;
    logic step_req_o, train_mode_o, dp_rst_o, busy_o, done_o;
    logic [LANES-1:0][DLY_W-1:0] res_start_o, res_end_o, center_o;
    logic [LANES-1:0][LEN_W-1:0] width_o;
    logic [LANES-1:0][CW-1:0] code_p_o, code_n_o;
    logic [LANES-1:0] fail_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rsd_sweep_top dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .step_done_i(step_done_i),
        .fb_i(fb_i), .delay_o(delay_o), .step_req_o(step_req_o),
        .train_mode_o(train_mode_o), .dp_rst_o(dp_rst_o), .busy_o(busy_o),
        .res_start_o(res_start_o), .res_end_o(res_end_o), .width_o(width_o),
        .center_o(center_o), .code_p_o(code_p_o), .code_n_o(code_n_o),
        .fail_o(fail_o), .done_o(done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Tester feedback per test, lane and offset
    function automatic int fb_of(input int t, input int l, input int d);
        if (t == 1) begin
            case (l)
                0: return (d >= -10 && d <= 10) ? 1 : 0;
                1: return ((d >= -30 && d <= -20) || (d >= 0 && d <= 12)) ? 1 : 3;
                2: return 0;
                default: return (d >= 20) ? 1 : ((d % 2 != 0) ? 2 : 3);
            endcase
        end else begin
            case (l)
                0: return (d <= -20 || (d >= 5 && d <= 17)) ? 1 : 0;
                1: return 1;
                2: return (d >= -5 && d <= 7) ? 1 : 2;
                default: return (d % 2 == 0) ? 1 : 0;
            endcase
        end
    endfunction

    function automatic int floor_half(input int v);
        return (v >= 0) ? v / 2 : -((-v + 1) / 2);
    endfunction

    task automatic run_sweep(input int t);
        int ex_s[LANES], ex_len[LANES];
        // behavioural expectation from the requirements
        for (int l = 0; l < LANES; l++) begin
            int cs = 0, cl = 0;
            ex_s[l] = -32; ex_len[l] = 0;
            for (int d = -32; d < 32; d++) begin
                if (fb_of(t, l, d) == 1) begin
                    if (cl == 0) cs = d;
                    cl++;
                    if (cl > ex_len[l]) begin ex_len[l] = cl; ex_s[l] = cs; end
                end else cl = 0;
            end
        end
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < 64; i++) begin
            int lat = i % 3;
            while (!step_req_o) @(negedge clk);
            check("R2 offset", $signed(delay_o), -32 + i);
            check("R8 code held", code_p_o[i % LANES] + code_n_o[i % LANES], 64);
            check("R9 train mode", train_mode_o, 1);
            for (int k = 0; k < lat; k++) begin
                if (t == 2 && i == 10) start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                check("R3 wait", step_req_o, 1);
                check("R3 stable", $signed(delay_o), -32 + i);
            end
            for (int l = 0; l < LANES; l++) fb_i[l] = FB_W'(fb_of(t, l, -32 + i));
            step_done_i = 1'b1;
            @(negedge clk);
            fb_i = '0;
            step_done_i = (i % 5 == 0);
            check("R9 reset pulse", dp_rst_o, 1);
            check("R9 no request", step_req_o + train_mode_o, 0);
            @(negedge clk);
            step_done_i = 1'b0;
            check("R9 reset single", dp_rst_o, 0);
            if (i != 63) check("R10 no early done", done_o, 0);
        end
        @(negedge clk);
        check("R10 done", done_o, 1);
        for (int l = 0; l < LANES; l++) begin
            int e = (ex_len[l] == 0) ? ex_s[l] : ex_s[l] + ex_len[l] - 1;
            int c = (ex_len[l] == 0) ? ex_s[l] : floor_half(ex_s[l] + e);
            check("R5 start", $signed(res_start_o[l]), ex_s[l]);
            check("R6 end", $signed(res_end_o[l]), e);
            check("R6 width", width_o[l], ex_len[l]);
            check("R6 center", $signed(center_o[l]), c);
            check("R7 flag", fail_o[l], (ex_len[l] <= 12) ? 1 : 0);
            check("R8 code p", code_p_o[l], c + 32);
            check("R8 code n", code_n_o[l], c + 32);
        end
        @(negedge clk);
        check("R10 pulse", done_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done", done_o, 0);
        check("R1 req", step_req_o + train_mode_o + dp_rst_o, 0);
        for (int l = 0; l < LANES; l++) begin
            check("R1 code p", code_p_o[l], 32);
            check("R1 code n", code_n_o[l], 32);
        end
        // R3: stray completion while idle does nothing
        step_done_i = 1'b1;
        @(negedge clk);
        step_done_i = 1'b0;
        check("R3 idle ignore", step_req_o + busy_o, 0);
        run_sweep(1);
        // R4/R7 spot values of test 1
        check("R4 non-one fails", width_o[3], 12);
        check("R7 no pass", width_o[2], 0);
        run_sweep(2);
        check("R5 tie keeps earlier", $signed(res_start_o[0]), -32);
        check("R7 width 13 ok", fail_o[2], 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule